// File: doc/BRIEF.md
# Byte-Wide Instruction and Data Fetch Assembler

This block lets a datapath that consumes 16-bit instructions and 8-bit operands run from one memory that is 8 bits wide and 256 entries deep. Each instruction cycle has three sub-steps. The first two read instruction bytes from consecutive addresses given by an external instruction pointer. The third is a data access at an address that the current instruction supplies. That access is a read, a write of the datapath result, or nothing at all.

Read data returns one cycle after its address is presented. The block steers every returned byte with a 2-bit select. The select's upper bit is the phase, which is high only in the data sub-step. Its lower bit is the least significant bit of the address. The assembled instruction, the data latch and two one-cycle valid pulses go to the datapath. The block asks the external pointer logic to advance by one for each instruction byte it requests.

Top module: `byte_fetch_assembler`

## Requirements
- R1: During and after reset, until the first capture, `instr` and `data_byte` are zero, both valid pulses are low, and the first access made once `run` rises is an instruction-byte read at `ip`.
- R2: While `run` is high, the sub-steps rotate in the fixed order high fetch, low fetch, data access, one per cycle. While `run` is low, the sub-step holds, and `mem_en` and `ip_inc` are low.
- R3: In both fetch sub-steps, `mem_addr` equals `ip`, `mem_en` is 1, `mem_we` is 0 and `ip_inc` is 1.
- R4: In the data sub-step, `mem_addr` equals `data_addr` and `ip_inc` is 0. The `data_op` encoding is 01 = read (`mem_en` 1, `mem_we` 0), 10 = write (`mem_en` 1, `mem_we` 1, `mem_wdata` equal to `wr_data`), and 00 or 11 = no access (`mem_en` 0).
- R5: A read's byte is captured at the end of the cycle after its address, according to the select {phase, address bit 0}: 00 fills `instr[15:8]`, 01 fills `instr[7:0]`, and 1x fills `data_byte` whatever address bit 0 is. An odd instruction pointer in the high-fetch sub-step therefore fills the low half.
- R6: `instr_valid` is high for exactly the one cycle after a 01-select capture. `data_valid` is high for exactly the one cycle after a 1x-select capture.
- R7: A write or a no-access data sub-step leaves `data_byte` unchanged and raises no `data_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| run | input | 1 | Advance sub-steps and issue accesses |
| ip | input | 8 | Instruction pointer from the external pointer logic |
| ip_inc | output | 1 | Request to advance the pointer by one |
| data_addr | input | 8 | Data address from the current instruction |
| data_op | input | 2 | Data access kind (see R4) |
| wr_data | input | 8 | Datapath result to be written |
| mem_addr | output | 8 | Memory address |
| mem_en | output | 1 | Memory enable |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| instr | output | 16 | Assembled instruction |
| instr_valid | output | 1 | Pulse: low byte just captured |
| data_byte | output | 8 | Data latch |
| data_valid | output | 1 | Pulse: data byte just captured |

## Verification
The bench targets pauses of `run` placed inside an instruction cycle. A design that dropped or re-issued the read still in flight would leave a stale half instruction, or would capture the byte twice. Odd data addresses check that the phase bit overrides address bit 0; a design that decoded only the address bit would corrupt `instr` instead of loading the data latch. A pointer forced to an odd value shows whether bytes are steered by address rather than by sub-step. Write-then-read of the same address, and the unused op code 11, expose a latch that captures on writes or treats 11 as an access.

// File: rtl/fas_pkg.sv
package fas_pkg;
  typedef enum logic [1:0] {ST_HI = 2'd0, ST_LO = 2'd1, ST_DATA = 2'd2} step_e;
  typedef enum logic [1:0] {DST_HI = 2'd0, DST_LO = 2'd1, DST_DATA = 2'd2} dst_e;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;

  // Byte steering: phase bit dominates, otherwise address bit 0 picks the half.
  function automatic dst_e steer_dest(input logic phase, input logic a0);
    if (phase) return DST_DATA;
    return a0 ? DST_LO : DST_HI;
  endfunction

  function automatic step_e step_after(input step_e s);
    case (s)
      ST_HI:   return ST_LO;
      ST_LO:   return ST_DATA;
      default: return ST_HI;
    endcase
  endfunction
endpackage

// File: rtl/fas_sequencer.sv
module fas_sequencer
  import fas_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  output step_e step,
  output logic  phase_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   step <= ST_HI;
    else if (run) step <= step_after(step);
  end

  assign phase_data = (step == ST_DATA);

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == ST_LO) |=> step == ST_DATA);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(step));
endmodule

// File: rtl/fas_addr_mux.sv
module fas_addr_mux
  import fas_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          run,
  input  logic          phase_data,
  input  logic [AW-1:0] ip,
  input  logic [AW-1:0] data_addr,
  input  logic [1:0]    data_op,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          ip_inc,
  output logic          rd_issue
);
  logic data_rd, data_wr;

  assign data_rd   = (data_op == OP_READ);
  assign data_wr   = (data_op == OP_WRITE);
  assign mem_addr  = phase_data ? data_addr : ip;
  assign mem_en    = run && (!phase_data || data_rd || data_wr);
  assign mem_we    = run && phase_data && data_wr;
  assign mem_wdata = wr_data;
  assign ip_inc    = run && !phase_data;
  assign rd_issue  = mem_en && !mem_we;
endmodule

// File: rtl/fas_byte_steer.sv
module fas_byte_steer
  import fas_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_issue,
  input  logic            phase_data,
  input  logic            addr_lsb,
  input  logic [DW-1:0]   mem_rdata,
  output logic [2*DW-1:0] instr,
  output logic            instr_valid,
  output logic [DW-1:0]   data_byte,
  output logic            data_valid
);
  localparam int IW = 2 * DW;

  logic pend;
  dst_e pend_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      pend_dst <= DST_HI;
    end else begin
      pend     <= rd_issue;
      pend_dst <= steer_dest(phase_data, addr_lsb);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr       <= '0;
      data_byte   <= '0;
      instr_valid <= 1'b0;
      data_valid  <= 1'b0;
    end else begin
      instr_valid <= pend && (pend_dst == DST_LO);
      data_valid  <= pend && (pend_dst == DST_DATA);
      if (pend) begin
        case (pend_dst)
          DST_HI:  instr[IW-1:DW] <= mem_rdata;
          DST_LO:  instr[DW-1:0]  <= mem_rdata;
          default: data_byte      <= mem_rdata;
        endcase
      end
    end
  end

  p_data_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_byte) |-> data_valid);
endmodule

// File: rtl/byte_fetch_assembler.sv
module byte_fetch_assembler
  import fas_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int IW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] ip,
  output logic          ip_inc,
  input  logic [AW-1:0] data_addr,
  input  logic [1:0]    data_op,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_en,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [IW-1:0] instr,
  output logic          instr_valid,
  output logic [DW-1:0] data_byte,
  output logic          data_valid
);
  step_e step;
  logic  phase_data;
  logic  rd_issue;

  fas_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .phase_data(phase_data)
  );

  fas_addr_mux #(.AW(AW), .DW(DW)) u_mux (
    .run(run), .phase_data(phase_data), .ip(ip), .data_addr(data_addr),
    .data_op(data_op), .wr_data(wr_data), .mem_addr(mem_addr), .mem_en(mem_en),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .ip_inc(ip_inc), .rd_issue(rd_issue)
  );

  fas_byte_steer #(.DW(DW)) u_steer (
    .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .phase_data(phase_data),
    .addr_lsb(mem_addr[0]), .mem_rdata(mem_rdata), .instr(instr),
    .instr_valid(instr_valid), .data_byte(data_byte), .data_valid(data_valid)
  );

  p_first_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == ST_HI) |=> step == ST_LO);
  p_ipinc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ip_inc |-> (mem_en && !mem_we));
  p_write_no_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> ##1 !data_valid);
  p_lo_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> $past(rd_issue && !phase_data && mem_addr[0], 2));
endmodule

// File: tb/byte_fetch_assembler_test.sv
module byte_fetch_assembler_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       run = 0;
  logic [7:0] pc;
  logic       ip_inc;
  logic [7:0] data_addr = 0;
  logic [1:0] data_op = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_en, mem_we;
  logic [15:0] instr;
  logic       instr_valid, data_valid;
  logic [7:0] data_byte;
  logic       force_pc = 0;
  logic [7:0] force_val = 0;

  int checks = 0, fails = 0;
  logic [7:0] ram [256];
  int m_mem [256];
  int m_step = 0;
  int m_hi = 0, m_lo = 0, m_data = 0, m_iv = 0, m_dv = 0;
  int p_v = 0, p_phase = 0, p_addr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_fetch_assembler uut (
    .clk(clk), .rst_n(rst_n), .run(run), .ip(pc), .ip_inc(ip_inc),
    .data_addr(data_addr), .data_op(data_op), .wr_data(wr_data),
    .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .instr(instr), .instr_valid(instr_valid),
    .data_byte(data_byte), .data_valid(data_valid)
  );

  // external pointer logic and memory array
  always @(posedge clk) begin
    if (!rst_n) pc <= 8'h00;
    else if (force_pc) pc <= force_val;
    else if (ip_inc) pc <= pc + 8'd1;
  end
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else mem_rdata <= ram[mem_addr];
    end
  end
  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'((i * 37 + 11) & 255);
      m_mem[i] = (i * 37 + 11) & 255;
    end
    mem_rdata = 0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model, compared every cycle
  always @(negedge clk) begin
    int e_en, e_we, e_addr, e_inc, is_rd, is_wr;
    if (!rst_n) begin
      m_step = 0; m_hi = 0; m_lo = 0; m_data = 0; m_iv = 0; m_dv = 0; p_v = 0;
    end else begin
      is_rd = (data_op == 2'b01);
      is_wr = (data_op == 2'b10);
      e_addr = (m_step == 2) ? int'(data_addr) : int'(pc);
      e_en = run && (m_step < 2 || is_rd || is_wr);
      e_we = run && m_step == 2 && is_wr;
      e_inc = run && m_step < 2;
      chk(run ? (m_step == 2 ? "R4" : "R3") : "R2", "mem_en", mem_en, e_en);
      chk(run ? (m_step == 2 ? "R4" : "R3") : "R2", "ip_inc", ip_inc, e_inc);
      chk(m_step == 2 ? "R4" : "R3", "mem_we", mem_we, e_we);
      if (e_en) chk(m_step == 2 ? "R4" : "R3", "mem_addr", mem_addr, e_addr);
      if (e_we) chk("R4", "mem_wdata", mem_wdata, wr_data);
      chk("R5", "instr", instr, (m_hi << 8) | m_lo);
      chk("R7", "data_byte", data_byte, m_data);
      chk("R6", "instr_valid", instr_valid, m_iv);
      chk("R6", "data_valid", data_valid, m_dv);
      m_iv = 0; m_dv = 0;
      if (p_v) begin
        if (p_phase) begin m_data = m_mem[p_addr]; m_dv = 1; end
        else if (p_addr % 2 == 1) begin m_lo = m_mem[p_addr]; m_iv = 1; end
        else m_hi = m_mem[p_addr];
      end
      p_v = e_en && !e_we;
      p_phase = (m_step == 2);
      p_addr = e_addr;
      if (e_en && e_we) m_mem[e_addr] = wr_data;
      if (run) m_step = (m_step + 1) % 3;
    end
  end

  task automatic drive(input bit r, input logic [7:0] da, input logic [1:0] op, input logic [7:0] wd);
    @(posedge clk); #1;
    run = r; data_addr = da; data_op = op; wr_data = wd;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "instr", instr, 0);
    chk("R1", "data_byte", data_byte, 0);
    chk("R1", "instr_valid", instr_valid, 0);
    chk("R1", "data_valid", data_valid, 0);
    // first access is a fetch at ip (R1)
    drive(1, 8'h80, 2'b00, 8'h00);
    @(negedge clk);
    chk("R1", "first mem_addr", mem_addr, pc);
    chk("R1", "first mem_we", mem_we, 0);
    // op mix with odd and even data addresses (R4, R5, R7)
    for (int k = 0; k < 40; k++) drive(1, 8'(8'h81 + k), 2'(k % 4), 8'(k * 13));
    // pauses inside instruction cycles (R2)
    for (int k = 0; k < 40; k++) drive((k % 5) != 2, 8'(8'hA0 + k), 2'b01, 8'(k));
    // misaligned pointer (R5)
    @(posedge clk); #1 force_pc = 1; force_val = 8'h41;
    @(posedge clk); #1 force_pc = 0;
    for (int k = 0; k < 15; k++) drive(1, 8'h33, 2'b01, 8'h00);
    // write then read back same addresses (R7, R4)
    for (int k = 0; k < 36; k++)
      drive(1, 8'(8'h90 + (k / 6) % 4), ((k / 3) % 2) ? 2'b01 : 2'b10, 8'(8'hC0 + k));
    drive(0, 8'h00, 2'b00, 8'h00);
    repeat (4) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule